// File: doc/BRIEF.md
# Non-Secure Interrupt Access Gate

This block holds one 2-bit delegation code for each interrupt line. With these codes, secure software decides how much of each secure interrupt's per-interrupt state non-secure software may touch. The codes are packed sixteen to a 32-bit control word. Secure software reaches the words through a small memory-mapped register port. The register window starts at byte offset 0xE00, and control word n sits at 0xE00 + 4n, for n from 0 to 63.

A second, purely combinational port answers permission queries from the rest of the interrupt controller. Each query carries an interrupt ID, whether that interrupt is secure, which kind of per-interrupt state is targeted, and whether the access is a read or a write. The answer is a single permit/deny bit.

Delegation is graded, and each code grants everything the codes below it grant. Two words follow their own rules. Word 0 covers the software-generated interrupts (IDs 0–15): there, code 11 behaves as 10, and the whole word disappears while affinity routing is enabled for the secure state. Word 1 covers the private peripheral interrupts (IDs 16–31) and holds nothing.

Top module: `nsg_access_gate`

## Requirements
- R1: After reset every code is 00. Every control word reads 0. Every query about a secure interrupt is denied.
- R2: A secure write (reg_secure=1, reg_write=1) to offset 0xE00+4n stores reg_wdata into word n. Bits [2x+1:2x] of word n hold the code for interrupt 16n+x. A secure read of the same offset returns the stored word combinationally in the same cycle.
- R3: A non-secure register access reads 0 and leaves every stored code unchanged.
- R4: Word 1 always reads 0 and ignores writes. Fields for IDs at or above NUM_IRQ, including whole words past the last implemented interrupt, also read 0 and ignore writes.
- R5: When q_irq_secure=0, q_permit is 1 whatever the code, class or direction.
- R6: Class encodings are 0 set-pending, 1 clear-pending, 2 active, 3 routing, 4 set-SPI, 5 clear-SPI, 6 SGI generation, 7 unused. A secure interrupt with level 00 is denied everything. Level 01 or above permits set-pending reads and writes.
- R7: Level 10 or above also permits clear-pending reads and writes and active-state reads. Active-state writes are always denied for a secure interrupt.
- R8: Only level 11 permits routing reads and writes. For IDs 0–15, a stored 11 acts as 10, so routing stays denied while the word still reads back 11.
- R9: While route_aff_s=1, word 0 reads 0 and ignores writes. IDs 0–15 then act as level 00. Contents stored before are kept and reappear when route_aff_s returns to 0.
- R10: Set-SPI (needs level ≥01) and clear-SPI (needs ≥10) permit only writes, and only for IDs ≥32. SGI generation (needs ≥01) permits only writes, and only for IDs 0–15. Class 7 is always denied for a secure interrupt.
- R11: Accesses whose address is outside 0xE00–0xEFF, or not word aligned, read 0 and change no code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| route_aff_s | input | 1 | Affinity routing enabled for the secure state |
| reg_valid | input | 1 | Register access this cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_secure | input | 1 | Security attribute of the access (1 = secure) |
| reg_addr | input | REG_AW | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| q_id | input | ID_W | Interrupt ID being queried |
| q_irq_secure | input | 1 | Queried interrupt is secure |
| q_class | input | 3 | Targeted state class (encoding in R6) |
| q_write | input | 1 | Queried access is a write |
| q_permit | output | 1 | 1 = non-secure access allowed |

## Verification
The hardest case to reach is the overlap of word-0 rules. A stored 11 must read back as 11 yet grant only level-10 rights. It must also vanish entirely under affinity routing, with its contents surviving the toggle. The stimulus fills every word with a rotated pattern that puts all four codes into each word, then its complement. After each fill, the bench sweeps every ID, class and direction. Affinity routing is then switched on around a write attempt and a full sweep, and word 0 is read back once it is switched off again.

// File: rtl/nsg_pkg.sv
// Shared types and constants for the non-secure access gate.
// Assumes: sixteen 2-bit codes per 32-bit word, and at most 64 words.
package nsg_pkg;

    // Kind of per-interrupt state a non-secure access targets.
    typedef enum logic [2:0] {
        CLS_SET_PEND = 3'd0,
        CLS_CLR_PEND = 3'd1,
        CLS_ACT_RD   = 3'd2,
        CLS_ROUTE    = 3'd3,
        CLS_SET_SPI  = 3'd4,
        CLS_CLR_SPI  = 3'd5,
        CLS_SGI_GEN  = 3'd6,
        CLS_UNUSED   = 3'd7
    } nsg_class_e;

    // Effective delegation level after aliasing; the order is the grant order.
    typedef enum logic [1:0] {
        LVL_NONE     = 2'd0,
        LVL_PEND_SET = 2'd1,
        LVL_PEND_CLR = 2'd2,
        LVL_ROUTE    = 2'd3
    } nsg_level_e;

    localparam int CODES_PER_WORD = 16;
    localparam int WORD_SLOTS     = 64;
    localparam int PPI_WORD       = 1;
    localparam int SPI_FIRST_ID   = 32;

endpackage

// File: rtl/nsg_ctrl_bank.sv
// Storage of the per-interrupt delegation codes and the register port.
// Only secure, word-aligned accesses inside the 256-byte window are honoured.
// Word 1 and fields at or above NUM_IRQ hold no flops and read as zero.
// Word 0 is hidden (reads zero, ignores writes) while route_aff_s is high,
// but keeps its contents. Assumes NUM_IRQ <= 1024.
module nsg_ctrl_bank
    import nsg_pkg::*;
#(
    parameter int                NUM_IRQ   = 96,
    parameter int                REG_AW    = 12,
    parameter logic [REG_AW-1:0] BASE_ADDR = 12'hE00,
    parameter int                SLOT_W    = 7
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        route_aff_s,
    input  logic                        reg_valid,
    input  logic                        reg_write,
    input  logic                        reg_secure,
    input  logic [REG_AW-1:0]           reg_addr,
    input  logic [31:0]                 reg_wdata,
    output logic [31:0]                 reg_rdata,
    output logic [2*(1<<SLOT_W)-1:0]    fld_flat
);

    localparam int NSLOT = 1 << SLOT_W;

    logic        in_window;
    logic [5:0]  word_idx;
    logic        wr_ok;
    logic        rd_ok;
    logic [31:0] word_v [WORD_SLOTS];

    // Address decode: window match and word alignment.
    assign in_window = (reg_addr[REG_AW-1:8] == BASE_ADDR[REG_AW-1:8]) &&
                       (reg_addr[1:0] == 2'b00);
    assign word_idx  = reg_addr[7:2];
    assign wr_ok     = reg_valid && reg_write && reg_secure && in_window;
    assign rd_ok     = reg_valid && !reg_write && reg_secure && in_window &&
                       !((word_idx == 6'd0) && route_aff_s);

    for (genvar w = 0; w < WORD_SLOTS; w++) begin : g_word
        for (genvar x = 0; x < CODES_PER_WORD; x++) begin : g_fld
            localparam int ID = w * CODES_PER_WORD + x;
            if (w != PPI_WORD && ID < NUM_IRQ) begin : g_impl
                logic [1:0] code_q;
                // Code storage: reset to 00, load on a secure write to this word.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        code_q <= 2'b00;
                    end else if (wr_ok && (word_idx == 6'(w)) &&
                                 ((w != 0) || !route_aff_s)) begin
                        code_q <= reg_wdata[2*x +: 2];
                    end
                end
                assign word_v[w][2*x +: 2] = code_q;
            end else begin : g_ro
                assign word_v[w][2*x +: 2] = 2'b00;
            end
        end
    end

    // Read mux: zero unless a visible secure read hits the window.
    always_comb begin
        reg_rdata = '0;
        if (rd_ok) begin
            reg_rdata = word_v[word_idx];
        end
    end

    // Flatten codes into an ID-indexed vector for the query path.
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        assign fld_flat[2*s +: 2] = word_v[s / CODES_PER_WORD][2*(s % CODES_PER_WORD) +: 2];
    end

endmodule

// File: rtl/nsg_level_view.sv
// Turns the stored code of the queried interrupt into an effective level.
// Applies the out-of-range rule, the word-0 affinity hiding and the
// 11-to-10 alias for IDs 0-15. Assumes ID_W >= SLOT_W >= 5.
module nsg_level_view
    import nsg_pkg::*;
#(
    parameter int NUM_IRQ = 96,
    parameter int ID_W    = 10,
    parameter int SLOT_W  = 7
) (
    input  logic [2*(1<<SLOT_W)-1:0] fld_flat,
    input  logic [ID_W-1:0]          q_id,
    input  logic                     route_aff_s,
    output nsg_level_e               level
);

    logic       in_range;
    logic       is_sgi;
    logic [1:0] raw;

    assign in_range = (32'(q_id) < NUM_IRQ);
    assign is_sgi   = (q_id[ID_W-1:4] == '0);
    assign raw      = fld_flat[{q_id[SLOT_W-1:0], 1'b0} +: 2];

    // Level selection with the special rules for the lowest word.
    always_comb begin
        level = LVL_NONE;
        if (in_range) begin
            if (is_sgi) begin
                if (!route_aff_s) begin
                    level = (raw == 2'b11) ? LVL_PEND_CLR : nsg_level_e'(raw);
                end
            end else begin
                level = nsg_level_e'(raw);
            end
        end
    end

endmodule

// File: rtl/nsg_permit.sv
// Maps an effective level, a state class and a direction to permit/deny.
// Non-secure interrupts are never restricted. Purely combinational.
module nsg_permit
    import nsg_pkg::*;
#(
    parameter int ID_W = 10
) (
    input  nsg_level_e      level,
    input  logic [ID_W-1:0] q_id,
    input  logic            q_irq_secure,
    input  nsg_class_e      q_class,
    input  logic            q_write,
    output logic            q_permit
);

    logic is_sgi;
    logic is_spi;
    logic grant;

    assign is_sgi = (q_id[ID_W-1:4] == '0);
    assign is_spi = (32'(q_id) >= SPI_FIRST_ID);

    // Cumulative grant table per class.
    always_comb begin
        unique case (q_class)
            CLS_SET_PEND: grant = (level >= LVL_PEND_SET);
            CLS_CLR_PEND: grant = (level >= LVL_PEND_CLR);
            CLS_ACT_RD:   grant = (level >= LVL_PEND_CLR) && !q_write;
            CLS_ROUTE:    grant = (level == LVL_ROUTE);
            CLS_SET_SPI:  grant = q_write && is_spi && (level >= LVL_PEND_SET);
            CLS_CLR_SPI:  grant = q_write && is_spi && (level >= LVL_PEND_CLR);
            CLS_SGI_GEN:  grant = q_write && is_sgi && (level >= LVL_PEND_SET);
            default:      grant = 1'b0;
        endcase
    end

    assign q_permit = !q_irq_secure || grant;

endmodule

// File: rtl/nsg_access_gate.sv
// Top of the non-secure access gate: code bank, level view and permit table.
// Register reads and query answers are combinational; writes take effect
// at the next clock edge. Assumes NUM_IRQ <= 1024 and ID_W >= $clog2 of
// the rounded-up field count.
module nsg_access_gate
    import nsg_pkg::*;
#(
    parameter int                NUM_IRQ   = 96,
    parameter int                REG_AW    = 12,
    parameter logic [REG_AW-1:0] BASE_ADDR = 12'hE00,
    parameter int                ID_W      = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              route_aff_s,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic              reg_secure,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [ID_W-1:0]   q_id,
    input  logic              q_irq_secure,
    input  logic [2:0]        q_class,
    input  logic              q_write,
    output logic              q_permit
);

    localparam int NUM_WORDS = (NUM_IRQ + CODES_PER_WORD - 1) / CODES_PER_WORD;
    localparam int SLOT_W    = $clog2(NUM_WORDS * CODES_PER_WORD);

    logic [2*(1<<SLOT_W)-1:0] fld_flat;
    nsg_level_e               level;

    nsg_ctrl_bank #(
        .NUM_IRQ   (NUM_IRQ),
        .REG_AW    (REG_AW),
        .BASE_ADDR (BASE_ADDR),
        .SLOT_W    (SLOT_W)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .route_aff_s (route_aff_s),
        .reg_valid   (reg_valid),
        .reg_write   (reg_write),
        .reg_secure  (reg_secure),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .fld_flat    (fld_flat)
    );

    nsg_level_view #(
        .NUM_IRQ (NUM_IRQ),
        .ID_W    (ID_W),
        .SLOT_W  (SLOT_W)
    ) u_view (
        .fld_flat    (fld_flat),
        .q_id        (q_id),
        .route_aff_s (route_aff_s),
        .level       (level)
    );

    nsg_permit #(
        .ID_W (ID_W)
    ) u_permit (
        .level        (level),
        .q_id         (q_id),
        .q_irq_secure (q_irq_secure),
        .q_class      (nsg_class_e'(q_class)),
        .q_write      (q_write),
        .q_permit     (q_permit)
    );

endmodule

// File: rtl/nsg_access_gate_chk.sv
// Property checker for nsg_access_gate, attached by bind below.
// Observes ports and the flattened code vector only.
module nsg_access_gate_chk #(
    parameter int                REG_AW    = 12,
    parameter logic [REG_AW-1:0] BASE_ADDR = 12'hE00,
    parameter int                ID_W      = 10,
    parameter int                FLD_W     = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic              route_aff_s,
    input logic              reg_valid,
    input logic              reg_write,
    input logic              reg_secure,
    input logic [REG_AW-1:0] reg_addr,
    input logic [31:0]       reg_rdata,
    input logic [ID_W-1:0]   q_id,
    input logic              q_irq_secure,
    input logic [2:0]        q_class,
    input logic              q_write,
    input logic              q_permit,
    input logic [FLD_W-1:0]  fld_flat
);

    localparam logic [REG_AW-1:0] PPI_ADDR = BASE_ADDR + REG_AW'(4);

    p_ns_read_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && !reg_secure) |-> (reg_rdata == 32'd0));

    p_ns_write_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && reg_write && !reg_secure) |=> $stable(fld_flat));

    p_ppi_word_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && reg_addr == PPI_ADDR) |-> (reg_rdata == 32'd0));

    p_ns_irq_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !q_irq_secure |-> q_permit);

    p_active_wr_deny_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q_irq_secure && q_class == 3'd2 && q_write) |-> !q_permit);

    p_sgi_route_deny_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q_irq_secure && q_class == 3'd3 && q_id < ID_W'(16)) |-> !q_permit);

    p_aff_hide_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (route_aff_s && reg_valid && reg_addr == BASE_ADDR) |-> (reg_rdata == 32'd0));

    p_aff_hide_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (route_aff_s && reg_valid && reg_write && reg_addr == BASE_ADDR) |=> $stable(fld_flat));

    p_wo_read_deny_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q_irq_secure && !q_write && (q_class == 3'd4 || q_class == 3'd5 || q_class == 3'd6))
        |-> !q_permit);

endmodule

bind nsg_access_gate nsg_access_gate_chk #(
    .REG_AW    (REG_AW),
    .BASE_ADDR (BASE_ADDR),
    .ID_W      (ID_W),
    .FLD_W     (2*(1<<SLOT_W))
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .route_aff_s  (route_aff_s),
    .reg_valid    (reg_valid),
    .reg_write    (reg_write),
    .reg_secure   (reg_secure),
    .reg_addr     (reg_addr),
    .reg_rdata    (reg_rdata),
    .q_id         (q_id),
    .q_irq_secure (q_irq_secure),
    .q_class      (q_class),
    .q_write      (q_write),
    .q_permit     (q_permit),
    .fld_flat     (fld_flat)
);

// File: tb/test_nsg_access_gate.sv
// Sweep bench: 88 interrupt lines (word 5 half implemented), every word
// offset, every ID/class/direction, with expected values from a bench model.
module test_nsg_access_gate;

    localparam int          NUM_IRQ = 88;
    localparam int          AW      = 12;
    localparam logic [11:0] BASE    = 12'hE00;
    localparam int          IDW     = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             route_aff_s = 1'b0;
    logic             reg_valid = 1'b0;
    logic             reg_write = 1'b0;
    logic             reg_secure = 1'b0;
    logic [AW-1:0]    reg_addr = '0;
    logic [31:0]      reg_wdata = '0;
    logic [31:0]      reg_rdata;
    logic [IDW-1:0]   q_id = '0;
    logic             q_irq_secure = 1'b0;
    logic [2:0]       q_class = '0;
    logic             q_write = 1'b0;
    logic             q_permit;

    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;
    logic [31:0] exp_word [64];

    always #2 clk = ~clk;

    nsg_access_gate #(
        .NUM_IRQ (NUM_IRQ), .REG_AW (AW), .BASE_ADDR (BASE), .ID_W (IDW)
    ) i_nsg_access_gate (
        .clk (clk), .rst_n (rst_n), .route_aff_s (route_aff_s),
        .reg_valid (reg_valid), .reg_write (reg_write), .reg_secure (reg_secure),
        .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .q_id (q_id), .q_irq_secure (q_irq_secure), .q_class (q_class),
        .q_write (q_write), .q_permit (q_permit)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] impl_mask(input int w);
        logic [31:0] m = '0;
        if (w == 1) return '0;
        for (int x = 0; x < 16; x++)
            if (w * 16 + x < NUM_IRQ) m[2*x +: 2] = 2'b11;
        return m;
    endfunction

    function automatic logic [31:0] pattern(input int w, input bit inv);
        logic [63:0] t = {32'h1BE4D872, 32'h1BE4D872} >> (2 * (w % 16));
        return inv ? ~t[31:0] : t[31:0];
    endfunction

    function automatic int exp_level(input int id);
        int          w;
        logic [1:0]  f;
        if (id >= NUM_IRQ) return 0;
        w = id / 16;
        if (w == 1) return 0;
        if (w == 0 && route_aff_s) return 0;
        f = exp_word[w][2*(id % 16) +: 2];
        if (w == 0 && f == 2'b11) return 2;
        return int'(f);
    endfunction

    function automatic bit exp_permit(input int id, input bit sec, input int cls, input bit wr);
        int l = exp_level(id);
        if (!sec) return 1'b1;
        case (cls)
            0: return l >= 1;
            1: return l >= 2;
            2: return (l >= 2) && !wr;
            3: return l == 3;
            4: return wr && id >= 32 && l >= 1;
            5: return wr && id >= 32 && l >= 2;
            6: return wr && id < 16 && l >= 1;
            default: return 1'b0;
        endcase
    endfunction

    // Register write; updates the model the way R2/R3/R4/R9/R11 demand.
    task automatic reg_wr(input logic [11:0] addr, input logic [31:0] data, input bit sec);
        int w;
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_secure = sec;
        reg_addr = addr; reg_wdata = data;
        @(posedge clk);
        #1;
        reg_valid = 1'b0; reg_write = 1'b0;
        w = int'(addr[7:2]);
        if (sec && addr[11:8] == 4'hE && addr[1:0] == 2'b00 && !(w == 0 && route_aff_s))
            exp_word[w] = data & impl_mask(w);
    endtask

    task automatic reg_rd_chk(input logic [11:0] addr, input bit sec,
                              input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b0; reg_secure = sec; reg_addr = addr;
        #1;
        check(reg_rdata, exp, req);
        reg_valid = 1'b0;
    endtask

    task automatic read_all(input string req);
        for (int w = 0; w < 64; w++) begin
            logic [31:0] e = (w == 0 && route_aff_s) ? 32'd0 : exp_word[w];
            string r = (w == 1 || w >= 6) ? "R4" : req;
            reg_rd_chk(BASE + 12'(4 * w), 1'b1, e, r);
        end
    endtask

    task automatic sweep(input string req);
        for (int id = 0; id < 96; id++) begin
            for (int cls = 0; cls < 8; cls++) begin
                for (int wr = 0; wr < 2; wr++) begin
                    for (int sec = 0; sec < 2; sec++) begin
                        string r;
                        if (sec == 0)                   r = "R5";
                        else if (cls == 0)              r = "R6";
                        else if (cls == 1 || cls == 2)  r = "R7";
                        else if (cls == 3)              r = "R8";
                        else                            r = "R10";
                        @(negedge clk);
                        q_id = IDW'(id); q_class = 3'(cls);
                        q_write = wr[0]; q_irq_secure = sec[0];
                        #1;
                        check({31'd0, q_permit},
                              {31'd0, exp_permit(id, sec[0], cls, wr[0])},
                              $sformatf("%s/%s id=%0d cls=%0d wr=%0d", req, r, id, cls, wr));
                    end
                end
            end
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int w = 0; w < 64; w++) exp_word[w] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, through register reads and queries
        read_all("R1");
        sweep("R1");

        // R2 / R4: rotated pattern, then its complement, into every offset
        for (int w = 0; w < 64; w++) reg_wr(BASE + 12'(4 * w), pattern(w, 1'b0), 1'b1);
        read_all("R2");
        sweep("R2");
        for (int w = 0; w < 64; w++) reg_wr(BASE + 12'(4 * w), pattern(w, 1'b1), 1'b1);
        read_all("R2");
        sweep("R2");

        // R3: non-secure write ignored, non-secure read returns zero
        reg_wr(BASE + 12'h8, 32'h0000_0000, 1'b0);
        reg_rd_chk(BASE + 12'h8, 1'b1, exp_word[2], "R3");
        reg_rd_chk(BASE + 12'h8, 1'b0, 32'd0, "R3");

        // R11: outside the window or misaligned
        reg_wr(12'h100, 32'hFFFF_FFFF, 1'b1);
        reg_wr(12'hE0A, 32'h0000_0000, 1'b1);
        reg_wr(12'hF00, 32'h0000_0000, 1'b1);
        reg_rd_chk(12'h100, 1'b1, 32'd0, "R11");
        reg_rd_chk(12'hE0A, 1'b1, 32'd0, "R11");
        read_all("R11");

        // R8: word 0 all ones reads back 11 but grants level 10
        reg_wr(BASE, 32'hFFFF_FFFF, 1'b1);
        reg_rd_chk(BASE, 1'b1, 32'hFFFF_FFFF, "R8");
        sweep("R8");

        // R9: affinity hides word 0 and keeps its contents
        @(negedge clk);
        route_aff_s = 1'b1;
        reg_rd_chk(BASE, 1'b1, 32'd0, "R9");
        reg_wr(BASE, 32'h1234_5678, 1'b1);
        sweep("R9");
        @(negedge clk);
        route_aff_s = 1'b0;
        reg_rd_chk(BASE, 1'b1, 32'hFFFF_FFFF, "R9");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule